// File: doc/BRIEF.md
# System Bus Router Arbiter

This block decides who may use an on-chip system bus router in each cycle. It has two independent sides. On the request side, three ordinary initiators compete: a CPU, a DMA controller and a PCI controller. A debug initiator can override all of them. The ordinary initiators are served in least-recently-used order, which starts from a fixed order at reset. On the response side, seven target classes return responses, and one of them is chosen in each cycle by a fixed priority.

A request grant is a one-hot vector. It follows the pending valids combinationally, so a requester can be granted in the same cycle it raises valid. Once given, the grant is held until the downstream accept completes the handshake. Only a completed ordinary transfer rotates the least-recently-used order. A response grant acts as the ready of the chosen target. It is given only while the return path can accept. Address decoding and data movement are handled outside this block.

Top module: `sys_router_arb`

## Requirements
- R1: `reqGrant` is one-hot or zero. It is zero when no request valid or debug valid is pending and no grant is held. Bit 0 is the CPU, bit 1 the DMA controller, bit 2 the PCI controller and bit 3 the debug initiator. `reqValid` uses the same bit order for the three ordinary initiators.
- R2: After reset, if all three ordinary initiators request together, the CPU is granted. The reset order is CPU, then DMA controller, then PCI controller.
- R3: When an ordinary initiator completes a handshake, it moves to the lowest priority. The other two keep their relative order.
- R4: A grant completes in the cycle where it is asserted together with `reqAccept`. A grant that has not completed is held unchanged in the following cycles, even if the debug initiator requests. The order is unchanged until completion.
- R5: At any new arbitration, a pending debug request is granted (bit 3) ahead of all ordinary initiators.
- R6: A completed debug transfer leaves the least-recently-used order of the ordinary initiators unchanged.
- R7: `rspGrant` is one-hot or zero. It picks the lowest-numbered valid bit of `rspValid`. The bits, from highest to lowest priority, are: 0 peripheral bridge, 1 DMA controller, 2 CPU, 3 on-chip RAM, 4 local bus controller, 5 PCI controller, 6 DDR interface.
- R8: `rspGrant` is zero whenever `rspSinkReady` is low or no response is valid.
- R9: A synchronous active-high `rst` clears any held grant and restores the reset order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 3 | Request valids: CPU, DMA, PCI (bits 0..2) |
| dbgValid | input | 1 | Debug initiator request valid |
| reqAccept | input | 1 | Router accepts the granted request this cycle |
| reqGrant | output | 4 | One-hot request grant, bit 3 = debug |
| rspValid | input | 7 | Response valids by target class, bit 0 highest |
| rspSinkReady | input | 1 | Return path can take a response this cycle |
| rspGrant | output | 7 | One-hot response grant (ready to the target) |

## Verification
The grant is combinational from the stored state. A corrupted priority order therefore shows up as a wrong winner in the very next cycle in which two or more initiators contend. If nobody contends, it stays invisible. For that reason, the stimulus contends after every rotation, after a debug transfer and after a reset. A lost or stale held grant shows up in the cycle after a refused handshake, as a grant that changes or drops. A wrong response priority shows up in the same cycle, which is why the response valids are stepped through each position.

// File: rtl/sra_pkg.sv
package sra_pkg;
  parameter int unsigned INIT_CNT = 3;
  localparam int unsigned IDX_W = $clog2(INIT_CNT);
  localparam int unsigned GNT_W = INIT_CNT + 1;

  typedef logic [IDX_W-1:0] initIdx_t;

  // strobes from control to the order/lock datapath
  typedef struct packed {
    logic             setLock;
    logic [GNT_W-1:0] lockVec;
    logic             clrLock;
    logic             promote;
    initIdx_t         promotePos;
  } arbStrobe_t;
endpackage

// File: rtl/sra_dp.sv
module sra_dp
  import sra_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  arbStrobe_t                      stb,
  output logic [INIT_CNT-1:0][IDX_W-1:0]  order,
  output logic                            lockValid,
  output logic [GNT_W-1:0]                lockVec
);
  logic [INIT_CNT-1:0][IDX_W-1:0] orderNext;

  // move the entry at promotePos to the tail, shift the rest up
  always_comb begin
    orderNext = order;
    if (stb.promote) begin
      for (int k = 0; k < INIT_CNT - 1; k++) begin
        if (k >= int'(stb.promotePos)) orderNext[k] = order[k+1];
      end
      orderNext[INIT_CNT-1] = order[stb.promotePos];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < INIT_CNT; k++) order[k] <= IDX_W'(k);
      lockValid <= 1'b0;
      lockVec   <= '0;
    end else begin
      order <= orderNext;
      if (stb.setLock) begin
        lockValid <= 1'b1;
        lockVec   <= stb.lockVec;
      end else if (stb.clrLock) begin
        lockValid <= 1'b0;
        lockVec   <= '0;
      end
    end
  end
endmodule

// File: rtl/sra_ctrl.sv
module sra_ctrl
  import sra_pkg::*;
(
  input  logic [INIT_CNT-1:0]             reqValid,
  input  logic                            dbgValid,
  input  logic                            reqAccept,
  input  logic [INIT_CNT-1:0][IDX_W-1:0]  order,
  input  logic                            lockValid,
  input  logic [GNT_W-1:0]                lockVec,
  output logic [GNT_W-1:0]                reqGrant,
  output arbStrobe_t                      stb
);
  logic [GNT_W-1:0] freshGnt;
  logic [GNT_W-1:0] pendVec;
  logic             found;
  logic             done;
  logic             ordGrant;
  initIdx_t         grantPos;

  always_comb begin
    freshGnt = '0;
    found    = 1'b0;
    if (dbgValid) begin
      freshGnt[GNT_W-1] = 1'b1;
    end else begin
      for (int k = 0; k < INIT_CNT; k++) begin
        if (!found && reqValid[order[k]]) begin
          freshGnt[order[k]] = 1'b1;
          found = 1'b1;
        end
      end
    end
    reqGrant = lockValid ? lockVec : freshGnt;

    grantPos = '0;
    for (int k = 0; k < INIT_CNT; k++) begin
      if (reqGrant[order[k]]) grantPos = IDX_W'(k);
    end
    ordGrant = |reqGrant[INIT_CNT-1:0];
    pendVec  = {dbgValid, reqValid};
    done     = reqAccept && (|(reqGrant & pendVec));

    stb.setLock    = !lockValid && (|reqGrant) && !done;
    stb.lockVec    = reqGrant;
    stb.clrLock    = lockValid && done;
    stb.promote    = done && ordGrant;
    stb.promotePos = grantPos;
  end
endmodule

// File: rtl/sra_rsp_arb.sv
module sra_rsp_arb #(
  parameter int unsigned TGT_CNT = 7
) (
  input  logic [TGT_CNT-1:0] rspValid,
  input  logic               rspSinkReady,
  output logic [TGT_CNT-1:0] rspGrant
);
  logic [TGT_CNT-1:0] anyHigher;

  assign anyHigher[0] = 1'b0;
  for (genvar i = 1; i < TGT_CNT; i++) begin : g_chain
    assign anyHigher[i] = anyHigher[i-1] | rspValid[i-1];
  end
  for (genvar i = 0; i < TGT_CNT; i++) begin : g_gnt
    assign rspGrant[i] = rspSinkReady & rspValid[i] & ~anyHigher[i];
  end
endmodule

// File: rtl/sys_router_arb.sv
module sys_router_arb
  import sra_pkg::*;
#(
  parameter int unsigned TGT_CNT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INIT_CNT-1:0] reqValid,
  input  logic               dbgValid,
  input  logic               reqAccept,
  output logic [GNT_W-1:0]   reqGrant,
  input  logic [TGT_CNT-1:0] rspValid,
  input  logic               rspSinkReady,
  output logic [TGT_CNT-1:0] rspGrant
);
  arbStrobe_t                     stb;
  logic [INIT_CNT-1:0][IDX_W-1:0] order;
  logic                           lockValid;
  logic [GNT_W-1:0]               lockVec;

  sra_ctrl u_ctrl (
    .reqValid (reqValid),
    .dbgValid (dbgValid),
    .reqAccept(reqAccept),
    .order    (order),
    .lockValid(lockValid),
    .lockVec  (lockVec),
    .reqGrant (reqGrant),
    .stb      (stb)
  );

  sra_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .order    (order),
    .lockValid(lockValid),
    .lockVec  (lockVec)
  );

  sra_rsp_arb #(.TGT_CNT(TGT_CNT)) u_rsp (
    .rspValid    (rspValid),
    .rspSinkReady(rspSinkReady),
    .rspGrant    (rspGrant)
  );
endmodule

// File: rtl/sra_checker.sv
module sra_checker #(
  parameter int unsigned TGT_CNT = 7
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         reqValid,
  input logic               dbgValid,
  input logic               reqAccept,
  input logic [3:0]         reqGrant,
  input logic [TGT_CNT-1:0] rspValid,
  input logic               rspSinkReady,
  input logic [TGT_CNT-1:0] rspGrant,
  input logic               lockValid
);
  p_req_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reqGrant));

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!lockValid && reqValid == 3'b000 && !dbgValid) |-> reqGrant == 4'b0000);

  p_fresh_valid_r1: assert property (@(posedge clk) disable iff (rst)
    (!lockValid && reqGrant != 4'b0000) |-> ((reqGrant & {dbgValid, reqValid}) != 4'b0000));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (reqGrant != 4'b0000 && !reqAccept) |=> reqGrant == $past(reqGrant));

  p_dbg_first_r5: assert property (@(posedge clk) disable iff (rst)
    (dbgValid && !lockValid) |-> reqGrant[3]);

  p_rsp_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rspGrant));

  p_rsp_prio_r7: assert property (@(posedge clk) disable iff (rst)
    (rspGrant != '0) |-> (((rspGrant & rspValid) != '0) && ((rspValid & (rspGrant - 1'b1)) == '0)));

  p_rsp_none_r8: assert property (@(posedge clk) disable iff (rst)
    (!rspSinkReady || rspValid == '0) |-> rspGrant == '0);

  p_rst_clear_r9: assert property (@(posedge clk)
    rst |=> !lockValid);
endmodule

bind sys_router_arb sra_checker #(.TGT_CNT(TGT_CNT)) u_chk (.*);

// File: tb/sim_sys_router_arb.sv
module sim_sys_router_arb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reqValid = '0;
  logic       dbgValid = 1'b0;
  logic       reqAccept = 1'b0;
  logic [3:0] reqGrant;
  logic [6:0] rspValid = '0;
  logic       rspSinkReady = 1'b0;
  logic [6:0] rspGrant;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] expReq;
    logic [6:0] expRsp;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  sys_router_arb u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .dbgValid(dbgValid),
    .reqAccept(reqAccept), .reqGrant(reqGrant), .rspValid(rspValid),
    .rspSinkReady(rspSinkReady), .rspGrant(rspGrant)
  );

  // driver: apply one cycle of stimulus and queue the expected grants
  task automatic step(input logic [2:0] rv, input logic dv, input logic acc,
                      input logic [6:0] rs, input logic sr,
                      input logic [3:0] eg, input logic [6:0] er, input string tag);
    item_t it;
    @(negedge clk);
    reqValid = rv; dbgValid = dv; reqAccept = acc;
    rspValid = rs; rspSinkReady = sr;
    it.expReq = eg; it.expRsp = er; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compare mid low phase, after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        total++;
        if (reqGrant !== it.expReq) begin
          bad++;
          $display("FAIL %s reqGrant actual=%b expected=%b", it.tag, reqGrant, it.expReq);
        end
        total++;
        if (rspGrant !== it.expRsp) begin
          bad++;
          $display("FAIL %s rspGrant actual=%b expected=%b", it.tag, rspGrant, it.expRsp);
        end
      end
    end
  end

  initial begin
    #(4 * 5000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state, nothing pending
    step(3'b000, 0, 0, 7'h00, 1, 4'b0000, 7'h00, "R1 R8 idle");
    step(3'b111, 0, 1, 7'h7F, 1, 4'b0001, 7'h01, "R2 R7 reset order");
    step(3'b111, 0, 1, 7'h7E, 1, 4'b0010, 7'h02, "R3 R7 rotate");
    step(3'b111, 0, 0, 7'h7C, 1, 4'b0100, 7'h04, "R3 R7 third");
    step(3'b111, 1, 0, 7'h78, 1, 4'b0100, 7'h08, "R4 R7 held vs debug");
    step(3'b111, 0, 1, 7'h70, 1, 4'b0100, 7'h10, "R4 R7 complete");
    step(3'b111, 1, 0, 7'h60, 1, 4'b1000, 7'h20, "R5 R7 debug wins");
    step(3'b111, 1, 1, 7'h40, 1, 4'b1000, 7'h40, "R5 R7 debug done");
    step(3'b111, 0, 1, 7'h7F, 0, 4'b0001, 7'h00, "R6 R8 order kept");
    step(3'b101, 0, 1, 7'h41, 1, 4'b0100, 7'h01, "R3 R7 skip idle");
    step(3'b011, 0, 1, 7'h00, 1, 4'b0010, 7'h00, "R3 R8 kept order");
    step(3'b110, 0, 1, 7'h24, 1, 4'b0100, 7'h04, "R3 R7 pci");
    step(3'b001, 0, 1, 7'h00, 1, 4'b0001, 7'h00, "R3 cpu");
    step(3'b100, 0, 0, 7'h00, 1, 4'b0100, 7'h00, "R4 lock pci");
    @(negedge clk);
    reqValid = '0; dbgValid = 0; reqAccept = 0; rspValid = '0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step(3'b111, 0, 1, 7'h00, 1, 4'b0001, 7'h00, "R9 reset restores");
    step(3'b110, 0, 1, 7'h00, 1, 4'b0010, 7'h00, "R9 R3 after reset");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule